// File: doc/BRIEF.md
# Daisy-Chained Addressable Serial Control Slave

This block is the control-port slave of a single chip in a string of chips that all sit on one chip-select serial bus. Every chip wakes from reset at the same fixed address. Each chip also holds the reset of the chip after it through its chain enable output. Only the first chip in the string is awake at first. The host can therefore address it at the default address and give it a unique address. Setting the enable bit then wakes the next chip, which again answers at the default address. The host repeats this step down the string until every chip has its own address.

The slave oversamples chip select, serial clock and serial data with a fast system clock. A transfer opens with an address byte, continues with a register pointer byte and then carries data bytes. The slave answers reads and writes at its individual address. It also takes writes, but never reads, at either of two group addresses, so the host can broadcast settings to many chips at once. Any other address makes the slave ignore the rest of the transfer. Serial data out has a separate output enable so that a pad driver can tri-state it.

Top module: `chain_ctrl_slave`

## Requirements
- R1: While `rst_n` is low, `chain_en` is low. The registers return to their defaults: individual address 7'h40 with the enable bit 0, group 1 address 7'h7E and group 2 address 7'h7F.
- R2: `chain_en` follows the enable bit, which is bit 0 of the register at pointer 8'h00. A write of that register with bit 0 at 1 raises `chain_en`. A write with bit 0 at 0 leaves it low.
- R3: A transfer begins when `cs_n` falls. Bits are sampled on rising `sclk`, most significant bit first. Byte 0 carries the chip address in bits 7:1 and a flag in bit 0, where 0 means write and 1 means read. Byte 1 is the register pointer. Each data byte after it goes to the current pointer, and the pointer then steps by one.
- R4: After reset the chip answers at address 7'h40.
- R5: One write to pointer 8'h00 loads a new address from bits 7:1 and the enable bit from bit 0 together. From the next transfer on, the chip answers at the new address and ignores the old one.
- R6: A write whose byte 0 matches the group 1 or group 2 address is applied. Pointer 8'h01 holds the group 1 address and pointer 8'h02 the group 2 address, each in bits 7:1, and bit 0 of both reads back as 0.
- R7: A read whose byte 0 matches only a group address is ignored: `sdo_oe` stays low.
- R8: If byte 0 matches none of the chip's addresses, the chip ignores every later byte until `cs_n` rises. No register changes and `sdo_oe` stays low.
- R9: In a read at the individual address, `sdo` shifts out the addressed register on falling `sclk` edges, most significant bit first, starting after the pointer byte, with `sdo_oe` high. Outside such a read `sdo_oe` is low. Pointers other than 8'h00 to 8'h02 read as 8'h00 and ignore writes.
- R10: All 128 seven-bit values are valid individual addresses, including 7'h00 and 7'h7F.
- R11: A chip whose `rst_n` is driven by the previous chip's `chain_en` stays silent until that enable rises. It then answers at 7'h40.
- R12: A data byte cut short by `cs_n` rising is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, usually driven by the previous chip's chain enable |
| cs_n | input | 1 | Active-low chip select shared by the whole chain |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; the pad is high impedance when low |
| chain_en | output | 1 | Releases the next chip in the chain from reset |

## Verification
The hardest situation to bring about is two chips on the same bus that share the default address, where only the chain enable decides which one answers. The bench instantiates two slaves on common bus wires and drives the second one's reset from the first one's chain enable. A single combined write moves the first chip off 7'h40 and wakes the second. The bench then checks that the same read at 7'h40 is answered by the second chip and not the first. Later it drops the first chip's reset and checks that the second chip falls silent again.

// File: rtl/chain_pkg.sv
package chain_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [BYTE_W-1:0] PTR_IND  = 8'h00;
    localparam logic [BYTE_W-1:0] PTR_GRP1 = 8'h01;
    localparam logic [BYTE_W-1:0] PTR_GRP2 = 8'h02;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_PTR,
        PH_DATA,
        PH_SKIP
    } phase_e;
endpackage

// File: rtl/chain_sync.sv
module chain_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic sdi_i,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);
    localparam logic [2:0] IDLE_PINS = 3'b010;

    typedef struct packed {
        logic [STAGES-1:0][2:0] pipe;
        logic                   sclk_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.pipe[0] = {sclk_i, cs_n_i, sdi_i};
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.sclk_prev = s_q.pipe[STAGES-1][2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pipe      <= {STAGES{IDLE_PINS}};
            s_q.sclk_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_rise = s_q.pipe[STAGES-1][2] & ~s_q.sclk_prev;
    assign sclk_fall = ~s_q.pipe[STAGES-1][2] & s_q.sclk_prev;
    assign cs_act    = ~s_q.pipe[STAGES-1][1];
    assign sdi_s     = s_q.pipe[STAGES-1][0];

    a_r3_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_rise && sclk_fall));
endmodule

// File: rtl/chain_frame.sv
module chain_frame
    import chain_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              sdi_s,
    input  logic [ADDR_W-1:0] ind_addr,
    input  logic [ADDR_W-1:0] grp1_addr,
    input  logic [ADDR_W-1:0] grp2_addr,
    input  logic [BYTE_W-1:0] rdata,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_ptr,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_ptr,
    output logic              sdo,
    output logic              sdo_oe
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic [BYTE_W-1:0]  ptr;
        logic               rd;
        logic [BYTE_W-1:0]  tx;
        logic               drv;
    } frame_t;

    frame_t             f_d, f_q;
    logic [BYTE_W-1:0]  byte_in;
    logic               hit_ind, hit_grp;

    assign byte_in = {f_q.shreg[BYTE_W-2:0], sdi_s};
    assign hit_ind = (byte_in[BYTE_W-1:1] == ind_addr);
    assign hit_grp = (byte_in[BYTE_W-1:1] == grp1_addr) || (byte_in[BYTE_W-1:1] == grp2_addr);

    always_comb begin
        f_d     = f_q;
        wr_en   = 1'b0;
        wr_ptr  = f_q.ptr;
        wr_data = byte_in;
        if (!cs_act) begin
            f_d.phase  = PH_ADDR;
            f_d.bitcnt = '0;
            f_d.rd     = 1'b0;
            f_d.tx     = '0;
            f_d.drv    = 1'b0;
        end else begin
            if (sclk_rise && f_q.phase != PH_SKIP) begin
                f_d.shreg  = byte_in;
                f_d.bitcnt = f_q.bitcnt + 1'b1;
                if (f_q.bitcnt == LAST_BIT) begin
                    unique case (f_q.phase)
                        PH_ADDR: begin
                            f_d.rd = byte_in[0];
                            if (hit_ind || (hit_grp && !byte_in[0])) f_d.phase = PH_PTR;
                            else                                     f_d.phase = PH_SKIP;
                        end
                        PH_PTR: begin
                            f_d.ptr   = byte_in;
                            f_d.phase = PH_DATA;
                        end
                        PH_DATA: begin
                            wr_en     = !f_q.rd;
                            f_d.ptr   = f_q.ptr + 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
            if (sclk_fall && f_q.phase == PH_DATA && f_q.rd) begin
                f_d.drv = 1'b1;
                if (f_q.bitcnt == '0) f_d.tx = rdata;
                else                  f_d.tx = {f_q.tx[BYTE_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{phase: PH_ADDR, default: '0};
        end else begin
            f_q <= f_d;
        end
    end

    assign rd_ptr = f_q.ptr;
    assign sdo    = f_q.tx[BYTE_W-1];
    assign sdo_oe = f_q.drv & cs_act;

    a_r8_skip_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.phase == PH_SKIP) |-> !wr_en);
    a_r8_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.phase == PH_SKIP && cs_act) |=> (f_q.phase == PH_SKIP || f_q.phase == PH_ADDR));
    a_r9_drive_in_data: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (f_q.phase == PH_DATA));
    a_r12_idle_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (f_q.phase == PH_ADDR && f_q.bitcnt == '0));
endmodule

// File: rtl/chain_regs.sv
module chain_regs
    import chain_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEF_ADDR = 7'h40,
    parameter logic [ADDR_W-1:0] GRP1_DEF = 7'h7E,
    parameter logic [ADDR_W-1:0] GRP2_DEF = 7'h7F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [BYTE_W-1:0] rd_ptr,
    output logic [BYTE_W-1:0] rdata,
    output logic [ADDR_W-1:0] ind_addr,
    output logic [ADDR_W-1:0] grp1_addr,
    output logic [ADDR_W-1:0] grp2_addr,
    output logic              chain_en
);
    typedef struct packed {
        logic [ADDR_W-1:0] ind;
        logic              en;
        logic [ADDR_W-1:0] g1;
        logic [ADDR_W-1:0] g2;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_ptr)
                PTR_IND: begin
                    r_d.ind = wr_data[BYTE_W-1:1];
                    r_d.en  = wr_data[0];
                end
                PTR_GRP1: r_d.g1 = wr_data[BYTE_W-1:1];
                PTR_GRP2: r_d.g2 = wr_data[BYTE_W-1:1];
                default: ;
            endcase
        end
        case (rd_ptr)
            PTR_IND:  rdata = {r_q.ind, r_q.en};
            PTR_GRP1: rdata = {r_q.g1, 1'b0};
            PTR_GRP2: rdata = {r_q.g2, 1'b0};
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{ind: DEF_ADDR, en: 1'b0, g1: GRP1_DEF, g2: GRP2_DEF};
        end else begin
            r_q <= r_d;
        end
    end

    assign ind_addr  = r_q.ind;
    assign grp1_addr = r_q.g1;
    assign grp2_addr = r_q.g2;
    assign chain_en  = r_q.en;

    a_r2_enable_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.en) |-> $past(wr_en && wr_ptr == PTR_IND && wr_data[0]));
    a_r5_addr_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.ind) |-> $past(wr_en && wr_ptr == PTR_IND));
endmodule

// File: rtl/chain_ctrl_slave.sv
module chain_ctrl_slave
    import chain_pkg::*;
#(
    parameter logic [ADDR_W-1:0] DEF_ADDR    = 7'h40,
    parameter logic [ADDR_W-1:0] GRP1_DEF    = 7'h7E,
    parameter logic [ADDR_W-1:0] GRP2_DEF    = 7'h7F,
    parameter int                SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_oe,
    output logic chain_en
);
    logic              sclk_rise, sclk_fall, cs_act, sdi_s;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_ptr, wr_data, rd_ptr, rdata;
    logic [ADDR_W-1:0] ind_addr, grp1_addr, grp2_addr;

    chain_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_i    (sclk),
        .cs_n_i    (cs_n),
        .sdi_i     (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s)
    );

    chain_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s),
        .ind_addr  (ind_addr),
        .grp1_addr (grp1_addr),
        .grp2_addr (grp2_addr),
        .rdata     (rdata),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .rd_ptr    (rd_ptr),
        .sdo       (sdo),
        .sdo_oe    (sdo_oe)
    );

    chain_regs #(
        .DEF_ADDR (DEF_ADDR),
        .GRP1_DEF (GRP1_DEF),
        .GRP2_DEF (GRP2_DEF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .wr_data   (wr_data),
        .rd_ptr    (rd_ptr),
        .rdata     (rdata),
        .ind_addr  (ind_addr),
        .grp1_addr (grp1_addr),
        .grp2_addr (grp2_addr),
        .chain_en  (chain_en)
    );

    a_r1_chain_low_in_reset: assert property (@(posedge clk)
        !rst_n |-> !chain_en);
endmodule

// File: tb/chain_ctrl_slave_tb.sv
module chain_ctrl_slave_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo0, oe0, en0, sdo1, oe1, en1;
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    chain_ctrl_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo0), .sdo_oe(oe0), .chain_en(en0)
    );

    chain_ctrl_slave u_next (
        .clk(clk), .rst_n(en0), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo1), .sdo_oe(oe1), .chain_en(en1)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx0, output logic [7:0] rx1,
                         output logic o0, output logic o1);
        o0 = 1'b0;
        o1 = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk) sdi = tx[i];
            repeat (7) @(negedge clk);
            rx0[i] = sdo0;
            rx1[i] = sdo1;
            o0 |= oe0;
            o1 |= oe1;
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic fbegin;
        @(negedge clk) cs_n = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic fend;
        repeat (8) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d);
        logic [7:0] r0, r1;
        logic o0, o1;
        fbegin();
        xbyte({a, 1'b0}, r0, r1, o0, o1);
        xbyte(p, r0, r1, o0, o1);
        xbyte(d, r0, r1, o0, o1);
        fend();
    endtask

    task automatic rd(input logic [6:0] a, input logic [7:0] p, output logic [7:0] v0,
                      output logic [7:0] v1, output logic o0, output logic o1);
        logic [7:0] r0, r1;
        logic q0, q1;
        fbegin();
        xbyte({a, 1'b1}, r0, r1, q0, q1);
        xbyte(p, r0, r1, q0, q1);
        xbyte(8'h00, v0, v1, o0, o1);
        fend();
    endtask

    task automatic t_reset;
        chk(en0 == 1'b0, "R1 chain_en low in reset", {7'd0, en0}, 8'h00);
        chk(oe0 == 1'b0, "R1 sdo_oe low in reset", {7'd0, oe0}, 8'h00);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(en0 == 1'b0, "R1 chain_en low after release", {7'd0, en0}, 8'h00);
    endtask

    task automatic t_default;
        logic [7:0] v0, v1;
        logic o0, o1;
        rd(7'h40, 8'h00, v0, v1, o0, o1);
        chk(o0 && v0 == 8'h80, "R4 default address read", v0, 8'h80);
        chk(!o1, "R11 next chip silent while held", {7'd0, o1}, 8'h00);
        rd(7'h40, 8'h01, v0, v1, o0, o1);
        chk(v0 == 8'hFC, "R1 group1 default", v0, 8'hFC);
        rd(7'h40, 8'h02, v0, v1, o0, o1);
        chk(v0 == 8'hFE, "R9 group2 default read", v0, 8'hFE);
        wr(7'h40, 8'h00, 8'h80);
        chk(en0 == 1'b0, "R2 enable stays low with bit0 clear", {7'd0, en0}, 8'h00);
    endtask

    task automatic t_mismatch;
        logic [7:0] v0, v1, r0, r1;
        logic o0, o1;
        fbegin();
        xbyte(8'h82, r0, r1, o0, o1);
        xbyte(8'h80, r0, r1, o0, o1);
        xbyte(8'h01, r0, r1, o0, o1);
        xbyte(8'h00, r0, r1, o0, o1);
        xbyte(8'h25, r0, r1, o0, o1);
        fend();
        rd(7'h40, 8'h00, v0, v1, o0, o1);
        chk(v0 == 8'h80, "R8 mismatch frame ignored", v0, 8'h80);
        chk(en0 == 1'b0, "R8 no enable from ignored frame", {7'd0, en0}, 8'h00);
        rd(7'h41, 8'h00, v0, v1, o0, o1);
        chk(!o0, "R8 mismatch read undriven", {7'd0, o0}, 8'h00);
    endtask

    task automatic t_abort;
        logic [7:0] v0, v1, r0, r1;
        logic o0, o1;
        fbegin();
        xbyte(8'h80, r0, r1, o0, o1);
        xbyte(8'h01, r0, r1, o0, o1);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) sdi = 1'b0;
            repeat (7) @(negedge clk);
            sclk = 1'b1;
            repeat (8) @(negedge clk);
            sclk = 1'b0;
        end
        fend();
        rd(7'h40, 8'h01, v0, v1, o0, o1);
        chk(v0 == 8'hFC, "R12 partial byte discarded", v0, 8'hFC);
    endtask

    task automatic t_assign;
        logic [7:0] v0, v1;
        logic o0, o1;
        wr(7'h40, 8'h00, 8'h23);
        chk(en0 == 1'b1, "R2 enable set by combined write", {7'd0, en0}, 8'h01);
        rd(7'h40, 8'h00, v0, v1, o0, o1);
        chk(!o0, "R5 old address ignored", {7'd0, o0}, 8'h00);
        chk(o1 && v1 == 8'h80, "R11 next chip answers default", v1, 8'h80);
        rd(7'h11, 8'h00, v0, v1, o0, o1);
        chk(o0 && v0 == 8'h23, "R5 new address answers", v0, 8'h23);
        chk(!o1, "R5 next chip silent at other address", {7'd0, o1}, 8'h00);
    endtask

    task automatic t_group;
        logic [7:0] v0, v1;
        logic o0, o1;
        wr(7'h7F, 8'h02, 8'h54);
        rd(7'h11, 8'h02, v0, v1, o0, o1);
        chk(v0 == 8'h54, "R6 group write chip0", v0, 8'h54);
        rd(7'h40, 8'h02, v0, v1, o0, o1);
        chk(v1 == 8'h54, "R6 group write chip1", v1, 8'h54);
        wr(7'h2A, 8'h01, 8'h67);
        rd(7'h40, 8'h01, v0, v1, o0, o1);
        chk(v1 == 8'h66, "R6 group2 write, bit0 reads zero", v1, 8'h66);
        rd(7'h33, 8'h00, v0, v1, o0, o1);
        chk(!o0 && !o1, "R7 group read ignored", {6'd0, o1, o0}, 8'h00);
    endtask

    task automatic t_autoinc;
        logic [7:0] r0, r1, a0, b0;
        logic o0, o1;
        fbegin();
        xbyte(8'h22, r0, r1, o0, o1);
        xbyte(8'h01, r0, r1, o0, o1);
        xbyte(8'h10, r0, r1, o0, o1);
        xbyte(8'h20, r0, r1, o0, o1);
        fend();
        fbegin();
        xbyte(8'h23, r0, r1, o0, o1);
        xbyte(8'h01, r0, r1, o0, o1);
        xbyte(8'h00, a0, r1, o0, o1);
        xbyte(8'h00, b0, r1, o0, o1);
        fend();
        chk(a0 == 8'h10, "R3 first data byte at pointer", a0, 8'h10);
        chk(b0 == 8'h20, "R3 pointer stepped", b0, 8'h20);
    endtask

    task automatic t_unmapped;
        logic [7:0] v0, v1;
        logic o0, o1;
        wr(7'h11, 8'h05, 8'hFF);
        rd(7'h11, 8'h05, v0, v1, o0, o1);
        chk(o0 && v0 == 8'h00, "R9 unmapped reads zero", v0, 8'h00);
        rd(7'h11, 8'h00, v0, v1, o0, o1);
        chk(v0 == 8'h23, "R9 unmapped write no effect", v0, 8'h23);
    endtask

    task automatic t_extremes;
        logic [7:0] v0, v1;
        logic o0, o1;
        wr(7'h40, 8'h00, 8'hFE);
        rd(7'h7F, 8'h00, v0, v1, o0, o1);
        chk(o1 && v1 == 8'hFE, "R10 address 7F", v1, 8'hFE);
        wr(7'h11, 8'h00, 8'h01);
        rd(7'h00, 8'h00, v0, v1, o0, o1);
        chk(o0 && v0 == 8'h01, "R10 address 00", v0, 8'h01);
    endtask

    task automatic t_rereset;
        logic [7:0] v0, v1;
        logic o0, o1;
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        chk(en0 == 1'b0, "R1 chain_en drops in reset", {7'd0, en0}, 8'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        rd(7'h40, 8'h00, v0, v1, o0, o1);
        chk(o0 && v0 == 8'h80, "R4 default after reset", v0, 8'h80);
        chk(!o1, "R11 next chip held again", {7'd0, o1}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_default();
        t_mismatch();
        t_abort();
        t_assign();
        t_group();
        t_autoinc();
        t_unmapped();
        t_extremes();
        t_rereset();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %h expected %h", 8'h01, 8'h00);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule